// File: doc/BRIEF.md
# Processor State and Exception Sequencer

This block owns the status word, the program counter and the two-deep instruction prefetch state of a small 32-bit core. The core runs either full-width 32-bit instructions or 16-bit compact instructions. Each clock the block takes at most one event: reset, interrupt entry, a jump that restores the saved status word, a plain register-driven jump, a status-word write, or a sequential step. It then updates the program counter and the prefetch registers to match.

Instruction memory sits behind a combinational fetch port. In the same cycle as the event, the block drives the request, the address and the size, and it captures the returned word at the clock edge. For a 16-bit fetch it keeps only the low half of the returned word. On interrupt entry the block gives the link value to the register file through a write strobe. Whenever the mode field of the status word changes, it reports the old and the new mode so that a separate banked register file can swap its banks. During reset it raises a clear strobe for the general registers.

Status-word layout used throughout: bits [4:0] hold the mode, bit 5 is the compact-state flag, and bit 7 is the interrupt mask.

Top module: `proc_state_seq`

## Requirements
- R1: In a reset cycle the block raises gprClear and makes a 32-bit fetch at the vector base. After the edge the status word is 0x000000D3, the PC is base+4, the current-instruction register is 0, and every saved status copy is cleared.
- R2: The vector base is 0xFFFF0000 when coreId is zero and 0x00000000 for any other coreId.
- R3: A jump to an odd target makes a 16-bit fetch at the target with bit 0 cleared. It sets the PC to that address plus 2 and sets status bit 5. The prefetch register takes the low 16 bits of fetchData, zero-extended.
- R4: A jump to an even target makes a 32-bit fetch at the target with bits 1:0 cleared. It sets the PC to that address plus 4 and clears status bit 5.
- R5: A step moves the prefetch register into curInstr and fetches at the PC, 16-bit when status bit 5 is set and 32-bit otherwise. It advances the PC by 2 or 4 to match.
- R6: While status bit 7 is set, an interrupt request is ignored: there is no link write and no status change, and a lower-priority event in the same cycle proceeds.
- R7: On interrupt entry the low 8 status bits become 0xD2 and the upper bits are kept. The old status word is stored as the saved copy for mode 0x12. A 32-bit fetch is made at base+0x18 and the PC becomes base+0x1C.
- R8: On interrupt entry linkWe pulses and linkData is the PC plus 2 if the old status bit 5 was set, otherwise the PC unchanged.
- R9: A restoring jump in modes 0x11, 0x12, 0x13, 0x17 or 0x1B loads the status word from that mode's saved copy. Bit 0 of jumpAddr is then replaced by the restored bit 5 before the R3/R4 width selection.
- R10: A restoring jump in any other mode pulses restoreErr and leaves the status word unchanged. The jump still takes place, with target bit 0 forced to the current bit 5.
- R11: When an interrupt entry, a valid restore or a status write changes status bits [4:0], modeChg pulses with modeOld and modeNew set to the old and new modes.
- R12: A status write loads every status bit from statWdata except bit 5, which keeps its value. It makes no fetch and leaves the PC unchanged.
- R13: Only one event is taken per clock, in the priority reset, unmasked interrupt, restoring jump, plain jump, status write, step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset event, highest priority |
| coreId | input | ID_W | Core identity, selects the vector base |
| irqReq | input | 1 | Interrupt request |
| restoreReq | input | 1 | Jump that restores the saved status word |
| jumpReq | input | 1 | Plain register-driven jump |
| jumpAddr | input | 32 | Jump target; bit 0 selects the instruction set |
| statWe | input | 1 | Status-word write |
| statWdata | input | 32 | Status-word write data |
| stepReq | input | 1 | Sequential step |
| fetchReq | output | 1 | Instruction fetch request this cycle |
| fetchAddr | output | 32 | Fetch address |
| fetchHalf | output | 1 | 1 = 16-bit fetch, 0 = 32-bit fetch |
| fetchData | input | 32 | Fetched word, same cycle |
| curInstr | output | 32 | Current instruction |
| prefInstr | output | 32 | Prefetched instruction |
| pcOut | output | 32 | Program counter |
| statusOut | output | 32 | Status word |
| linkWe | output | 1 | Link register write strobe |
| linkData | output | 32 | Link register value |
| gprClear | output | 1 | Clear strobe for the general registers |
| modeChg | output | 1 | Mode-change strobe to the banked register file |
| modeOld | output | 5 | Mode before the change |
| modeNew | output | 5 | Mode after the change |
| restoreErr | output | 1 | Restore attempted in a mode with no saved copy |

## Verification
The bench works through the alignment corner cases. It uses a jump target with bit 1 set and bit 0 clear, which a design that failed to clear bit 1 would fetch from a misaligned word. It uses an odd target that must clear only bit 0. It also makes a restoring jump whose jumpAddr bit 0 disagrees with the restored compact flag; a design that skipped the override would fetch with the wrong width. The link value is checked on interrupt entry from both instruction states, because an off-by-two error there only shows from the compact state. Other checks cover a restore from a mode with no saved copy, which must leave the status word alone, and simultaneous requests, which show whether the priority order is wrong. The memory model places junk in the upper half of 16-bit fetches to catch a missing zero-extension.

// File: rtl/psq_pkg.sv
package psq_pkg;
  localparam int XLEN  = 32;
  localparam int NSLOT = 5;
  localparam int TBIT  = 5;
  localparam int IBIT  = 7;
  localparam logic [7:0] RST_LOW = 8'hD3;
  localparam logic [7:0] IRQ_LOW = 8'hD2;
  localparam logic [2:0] SLOT_IRQ = 3'd1;

  typedef struct packed {
    logic doReset;
    logic doIrq;
    logic doRestore;
    logic doJump;
    logic doStatW;
    logic doStep;
  } stb_t;

  // bit 3 = mode owns a saved copy, bits 2:0 = its slot
  function automatic logic [3:0] modeLookup(input logic [4:0] m);
    case (m)
      5'h11:   return {1'b1, 3'd0};
      5'h12:   return {1'b1, 3'd1};
      5'h13:   return {1'b1, 3'd2};
      5'h17:   return {1'b1, 3'd3};
      5'h1B:   return {1'b1, 3'd4};
      default: return 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/psq_ctrl.sv
module psq_ctrl
  import psq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic irqReq,
  input  logic irqMask,
  input  logic restoreReq,
  input  logic jumpReq,
  input  logic statWe,
  input  logic stepReq,
  output stb_t stb
);
  logic irqTake;
  assign irqTake = irqReq && !irqMask;

  always_comb begin
    stb = '0;
    if (rst)             stb.doReset   = 1'b1;
    else if (irqTake)    stb.doIrq     = 1'b1;
    else if (restoreReq) stb.doRestore = 1'b1;
    else if (jumpReq)    stb.doJump    = 1'b1;
    else if (statWe)     stb.doStatW   = 1'b1;
    else if (stepReq)    stb.doStep    = 1'b1;
  end

  // R13
  one_event_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.doReset, stb.doIrq, stb.doRestore, stb.doJump, stb.doStatW, stb.doStep}));
endmodule

// File: rtl/psq_dpath.sv
module psq_dpath
  import psq_pkg::*;
#(
  parameter int               ID_W     = 2,
  parameter logic [XLEN-1:0]  VEC_HIGH = 32'hFFFF_0000,
  parameter logic [XLEN-1:0]  VEC_LOW  = 32'h0000_0000,
  parameter logic [XLEN-1:0]  IRQ_OFS  = 32'h0000_0018
) (
  input  logic            clk,
  input  logic            rst,
  input  stb_t            stb,
  input  logic [ID_W-1:0] coreId,
  input  logic [XLEN-1:0] jumpAddr,
  input  logic [XLEN-1:0] statWdata,
  input  logic [XLEN-1:0] fetchData,
  output logic            fetchReq,
  output logic [XLEN-1:0] fetchAddr,
  output logic            fetchHalf,
  output logic [XLEN-1:0] curInstr,
  output logic [XLEN-1:0] prefInstr,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] status,
  output logic            linkWe,
  output logic [XLEN-1:0] linkData,
  output logic            modeChg,
  output logic [4:0]      modeOld,
  output logic [4:0]      modeNew,
  output logic            restoreErr
);
  logic [XLEN-1:0] savedStat [NSLOT];
  logic [XLEN-1:0] vecBase, tgt, pcNext, statNext, restored;
  logic [3:0]      slotInfo;
  logic            slotOk, restoreOk, isJmp, tSel;

  assign vecBase   = (coreId == '0) ? VEC_HIGH : VEC_LOW;
  assign slotInfo  = modeLookup(status[4:0]);
  assign slotOk    = slotInfo[3];
  assign restoreOk = stb.doRestore && slotOk;
  assign restoreErr = stb.doRestore && !slotOk;

  always_comb begin
    restored = '0;
    for (int s = 0; s < NSLOT; s++)
      if (slotInfo[2:0] == 3'(s)) restored = savedStat[s];
  end

  assign tSel  = restoreOk ? restored[TBIT] : status[TBIT];
  assign isJmp = stb.doReset | stb.doIrq | stb.doRestore | stb.doJump;

  always_comb begin
    if (stb.doReset)        tgt = vecBase;
    else if (stb.doIrq)     tgt = vecBase + IRQ_OFS;
    else if (stb.doRestore) tgt = {jumpAddr[XLEN-1:1], tSel};
    else if (stb.doJump)    tgt = jumpAddr;
    else                    tgt = pc;
  end

  assign fetchHalf = isJmp ? tgt[0] : status[TBIT];
  assign fetchReq  = isJmp | stb.doStep;
  always_comb begin
    if (!isJmp)         fetchAddr = pc;
    else if (fetchHalf) fetchAddr = {tgt[XLEN-1:1], 1'b0};
    else                fetchAddr = {tgt[XLEN-1:2], 2'b00};
  end
  assign pcNext = fetchAddr + (fetchHalf ? 32'd2 : 32'd4);

  always_comb begin
    statNext = status;
    if (stb.doReset) begin
      statNext = {24'h0, RST_LOW};
    end else if (stb.doIrq) begin
      statNext = {status[XLEN-1:8], IRQ_LOW};
    end else if (stb.doRestore) begin
      if (slotOk) statNext = restored;
      statNext[TBIT] = fetchHalf;
    end else if (stb.doJump) begin
      statNext[TBIT] = fetchHalf;
    end else if (stb.doStatW) begin
      statNext = statWdata;
      statNext[TBIT] = status[TBIT];
    end
  end

  assign linkWe   = stb.doIrq;
  assign linkData = pc + (status[TBIT] ? 32'd2 : 32'd0);
  assign modeOld  = status[4:0];
  assign modeNew  = statNext[4:0];
  assign modeChg  = (stb.doIrq | restoreOk | stb.doStatW) && (statNext[4:0] != status[4:0]);

  always_ff @(posedge clk) begin
    status <= statNext;
    if (fetchReq) begin
      pc        <= pcNext;
      prefInstr <= fetchHalf ? {16'h0, fetchData[15:0]} : fetchData;
    end
    if (stb.doReset)     curInstr <= '0;
    else if (stb.doStep) curInstr <= prefInstr;
    for (int s = 0; s < NSLOT; s++) begin
      if (stb.doReset)                                savedStat[s] <= '0;
      else if (stb.doIrq && 3'(s) == SLOT_IRQ)        savedStat[s] <= status;
    end
  end

  // R3
  pc_align_chk: assert property (@(posedge clk) disable iff (rst) !pc[0]);
  // R5
  step_adv_chk: assert property (@(posedge clk) disable iff (rst)
    stb.doStep |=> pc == $past(pc) + ($past(status[TBIT]) ? 32'd2 : 32'd4));
  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    restoreErr |=> status == $past(status));
  // R12
  statw_tbit_chk: assert property (@(posedge clk) disable iff (rst)
    stb.doStatW |=> (status[TBIT] == $past(status[TBIT])) && (pc == $past(pc)));
endmodule

// File: rtl/proc_state_seq.sv
module proc_state_seq
  import psq_pkg::*;
#(
  parameter int          ID_W     = 2,
  parameter logic [31:0] VEC_HIGH = 32'hFFFF_0000,
  parameter logic [31:0] VEC_LOW  = 32'h0000_0000,
  parameter logic [31:0] IRQ_OFS  = 32'h0000_0018
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ID_W-1:0] coreId,
  input  logic            irqReq,
  input  logic            restoreReq,
  input  logic            jumpReq,
  input  logic [31:0]     jumpAddr,
  input  logic            statWe,
  input  logic [31:0]     statWdata,
  input  logic            stepReq,
  output logic            fetchReq,
  output logic [31:0]     fetchAddr,
  output logic            fetchHalf,
  input  logic [31:0]     fetchData,
  output logic [31:0]     curInstr,
  output logic [31:0]     prefInstr,
  output logic [31:0]     pcOut,
  output logic [31:0]     statusOut,
  output logic            linkWe,
  output logic [31:0]     linkData,
  output logic            gprClear,
  output logic            modeChg,
  output logic [4:0]      modeOld,
  output logic [4:0]      modeNew,
  output logic            restoreErr
);
  stb_t stb;

  psq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .irqReq(irqReq), .irqMask(statusOut[IBIT]),
    .restoreReq(restoreReq), .jumpReq(jumpReq), .statWe(statWe),
    .stepReq(stepReq), .stb(stb)
  );

  psq_dpath #(.ID_W(ID_W), .VEC_HIGH(VEC_HIGH), .VEC_LOW(VEC_LOW), .IRQ_OFS(IRQ_OFS)) u_dpath (
    .clk(clk), .rst(rst), .stb(stb), .coreId(coreId), .jumpAddr(jumpAddr),
    .statWdata(statWdata), .fetchData(fetchData), .fetchReq(fetchReq),
    .fetchAddr(fetchAddr), .fetchHalf(fetchHalf), .curInstr(curInstr),
    .prefInstr(prefInstr), .pc(pcOut), .status(statusOut), .linkWe(linkWe),
    .linkData(linkData), .modeChg(modeChg), .modeOld(modeOld), .modeNew(modeNew),
    .restoreErr(restoreErr)
  );

  assign gprClear = stb.doReset;

  // R1
  rst_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (statusOut == 32'h0000_00D3) && (curInstr == 32'h0));
  // R6
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (irqReq && statusOut[IBIT]) |-> !linkWe);
endmodule

// File: tb/sim_proc_state_seq.sv
module sim_proc_state_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  coreId = 2'd0;
  logic        irqReq = 1'b0, restoreReq = 1'b0, jumpReq = 1'b0, statWe = 1'b0, stepReq = 1'b0;
  logic [31:0] jumpAddr = '0, statWdata = '0;
  logic        fetchReq, fetchHalf, linkWe, gprClear, modeChg, restoreErr;
  logic [31:0] fetchAddr, fetchData, curInstr, prefInstr, pcOut, statusOut, linkData;
  logic [4:0]  modeOld, modeNew;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return a ^ 32'hC0DE_0000;
  endfunction
  function automatic logic [31:0] memHalf(input logic [31:0] a);
    return {16'h0, a[15:0] ^ 16'hBEEF};
  endfunction
  // upper half carries junk on 16-bit fetches
  assign fetchData = fetchHalf ? {16'hFFFF, memHalf(fetchAddr)[15:0]} : memWord(fetchAddr);

  proc_state_seq u0 (
    .clk(clk), .rst(rst), .coreId(coreId), .irqReq(irqReq), .restoreReq(restoreReq),
    .jumpReq(jumpReq), .jumpAddr(jumpAddr), .statWe(statWe), .statWdata(statWdata),
    .stepReq(stepReq), .fetchReq(fetchReq), .fetchAddr(fetchAddr), .fetchHalf(fetchHalf),
    .fetchData(fetchData), .curInstr(curInstr), .prefInstr(prefInstr), .pcOut(pcOut),
    .statusOut(statusOut), .linkWe(linkWe), .linkData(linkData), .gprClear(gprClear),
    .modeChg(modeChg), .modeOld(modeOld), .modeNew(modeNew), .restoreErr(restoreErr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    irqReq = 0; restoreReq = 0; jumpReq = 0; statWe = 0; stepReq = 0;
  endtask

  // inputs are set at posedge+2, comb outputs seen at posedge+3
  task automatic edgeThen();
    @(posedge clk); #2;
    idle();
  endtask

  task automatic t_reset(input logic [1:0] id, input logic [31:0] base);
    rst = 1; coreId = id; jumpReq = 1; jumpAddr = 32'h0000_0777; #1;
    chk("R1 gprClear", 32'(gprClear), 1);
    chk("R13 reset beats jump fetchAddr", fetchAddr, base);
    chk("R1 fetchHalf", 32'(fetchHalf), 0);
    edgeThen(); rst = 0; #1;
    chk("R1 status", statusOut, 32'h0000_00D3);
    chk("R2 pc", pcOut, base + 4);
    chk("R1 pref", prefInstr, memWord(base));
    chk("R1 cur", curInstr, 0);
  endtask

  task automatic t_step(input logic [31:0] pc0, input logic half);
    logic [31:0] pref0;
    pref0 = prefInstr;
    stepReq = 1; #1;
    chk("R5 fetchAddr", fetchAddr, pc0);
    chk("R5 fetchHalf", 32'(fetchHalf), 32'(half));
    edgeThen(); #1;
    chk("R5 cur", curInstr, pref0);
    chk("R5 pref", prefInstr, half ? memHalf(pc0) : memWord(pc0));
    chk("R5 pc", pcOut, pc0 + (half ? 2 : 4));
  endtask

  task automatic t_masked();
    logic [31:0] pc0, st0;
    pc0 = pcOut; st0 = statusOut;
    irqReq = 1; stepReq = 1; #1;
    chk("R6 no link", 32'(linkWe), 0);
    chk("R6 step proceeds", fetchAddr, pc0);
    edgeThen(); #1;
    chk("R6 status", statusOut, st0);
    chk("R6 pc", pcOut, pc0 + 4);
  endtask

  task automatic t_statw(input logic [31:0] wd, input logic [31:0] expSt, input logic [4:0] m0);
    logic [31:0] pc0;
    pc0 = pcOut;
    statWe = 1; statWdata = wd; #1;
    chk("R12 no fetch", 32'(fetchReq), 0);
    chk("R11 modeChg", 32'(modeChg), 1);
    chk("R11 modeOld", 32'(modeOld), 32'(m0));
    chk("R11 modeNew", 32'(modeNew), 32'(wd[4:0]));
    edgeThen(); #1;
    chk("R12 status", statusOut, expSt);
    chk("R12 pc", pcOut, pc0);
  endtask

  task automatic t_jump(input logic [31:0] a, input logic [31:0] expFa, input logic half,
                        input logic [31:0] expSt);
    jumpReq = 1; jumpAddr = a; #1;
    chk(half ? "R3 fetchAddr" : "R4 fetchAddr", fetchAddr, expFa);
    chk(half ? "R3 fetchHalf" : "R4 fetchHalf", 32'(fetchHalf), 32'(half));
    edgeThen(); #1;
    chk(half ? "R3 pc" : "R4 pc", pcOut, expFa + (half ? 2 : 4));
    chk(half ? "R3 status" : "R4 status", statusOut, expSt);
    chk(half ? "R3 pref" : "R4 pref", prefInstr, half ? memHalf(expFa) : memWord(expFa));
  endtask

  task automatic t_irq(input logic [31:0] base, input logic [31:0] expLink, input logic [4:0] m0);
    logic [31:0] st0;
    st0 = statusOut;
    irqReq = 1; jumpReq = 1; jumpAddr = 32'h0000_0999; #1;
    chk("R8 linkWe", 32'(linkWe), 1);
    chk("R8 linkData", linkData, expLink);
    chk("R13 irq beats jump", fetchAddr, base + 32'h18);
    chk("R7 fetchHalf", 32'(fetchHalf), 0);
    chk("R11 irq modeChg", {modeChg, 3'b0, modeOld, 3'b0, modeNew}, {1'b1, 3'b0, m0, 3'b0, 5'h12});
    edgeThen(); #1;
    chk("R7 status", statusOut, {st0[31:8], 8'hD2});
    chk("R7 pc", pcOut, base + 32'h1C);
  endtask

  task automatic t_restore(input logic [31:0] a, input logic err, input logic [31:0] expFa,
                           input logic half, input logic [31:0] expSt);
    restoreReq = 1; jumpAddr = a; #1;
    chk(err ? "R10 restoreErr" : "R9 restoreErr", 32'(restoreErr), 32'(err));
    chk(err ? "R10 fetchAddr" : "R9 fetchAddr", fetchAddr, expFa);
    chk(err ? "R10 fetchHalf" : "R9 fetchHalf", 32'(fetchHalf), 32'(half));
    edgeThen(); #1;
    chk(err ? "R10 status" : "R9 status", statusOut, expSt);
    chk(err ? "R10 pc" : "R9 pc", pcOut, expFa + (half ? 2 : 4));
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(posedge clk); #2;
    t_reset(2'd0, 32'hFFFF_0000);                                   // R1 R2
    t_step(32'hFFFF_0004, 1'b0);                                    // R5 32-bit
    t_masked();                                                     // R6
    t_statw(32'hF000_003F, 32'hF000_001F, 5'h13);                   // R12 bit5 kept 0
    t_jump(32'h0000_0101, 32'h0000_0100, 1'b1, 32'hF000_003F);      // R3
    t_step(32'h0000_0102, 1'b1);                                    // R5 16-bit
    t_irq(32'hFFFF_0000, 32'h0000_0106, 5'h1F);                     // R7 R8 compact
    t_restore(32'h0000_0200, 1'b0, 32'h0000_0200, 1'b1, 32'hF000_003F); // R9
    t_restore(32'h0000_0300, 1'b1, 32'h0000_0300, 1'b1, 32'hF000_003F); // R10
    t_jump(32'h0000_1006, 32'h0000_1004, 1'b0, 32'hF000_001F);      // R4
    t_irq(32'hFFFF_0000, 32'h0000_1008, 5'h1F);                     // R8 full-width
    t_restore(32'h0000_0401, 1'b0, 32'h0000_0400, 1'b0, 32'hF000_001F); // R9 bit0 override
    t_reset(2'd1, 32'h0000_0000);                                   // R2 other core
    t_restore(32'h0000_0055, 1'b0, 32'h0000_0054, 1'b0, 32'h0000_0000); // R9 cleared copy
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule